// File: doc/BRIEF.md
# Switch Reset Sequencer

This block takes a multi-port Ethernet switch from an unknown configuration to a freshly reset one. It does the work through a single register request port. Each access names a device address and a register offset and completes on an acknowledge from the register access engine below. The sequencer does not move any bits on a management bus itself.

A one-cycle `start` pulse begins the sequence. The sequencer then works through each port in turn. For each port it reads the port control register and writes it back with the two-bit forwarding state cleared, which disables the port. Once all ports are disabled, it stays off the bus for a fixed drain interval. It then sets the self-clearing reset bit of the global control register with a read-modify-write. Finally it polls that bit at a fixed interval until the bit reads zero or the poll budget is used up.

The result is reported as exactly one pulse: completed, timed out, or access failure. The intervals are given in milliseconds and scaled by a clock-cycles-per-millisecond parameter.

Top module: `sw_reset_seq`

## Requirements
- R1: After reset, `busy`, `req_valid` and all three result pulses are low. A `start` pulse seen while idle makes `busy` high from the next cycle. `busy` stays high until the cycle in which a result pulse is shown, and in that cycle `busy` is low.
- R2: While `req_valid` is high and `ack` is low, `req_valid`, `req_write`, `req_dev`, `req_reg` and `req_wdata` hold their values. One acknowledge completes exactly one access.
- R3: Ports 0 to NUM_PORTS-1 (default 11) are handled in ascending order. Each port gets a read and then a write of device address 0x10+N, register offset 0x04. The written value equals the value read with bits 1:0 forced to 0 and every other bit kept.
- R4: From the acknowledge of the last port write to the first global access, `req_valid` stays low for exactly DRAIN_MS×CYCLES_PER_MS cycles.
- R5: The global control register is at device address 0x1B, offset 0x04. It is read once and then written with bit 15 set and every other bit as read.
- R6: After the global write, the global register is read back. The first read that returns bit 15 as 0 produces a `seq_done` pulse.
- R7: Between a poll read that returns bit 15 as 1 and the next poll read, `req_valid` stays low for exactly POLL_MS×CYCLES_PER_MS cycles.
- R8: If MAX_POLLS consecutive poll reads all return bit 15 as 1, `seq_timeout` pulses right after the last of them and no further access is issued.
- R9: An acknowledge with `ack_err` high, in any phase, ends the sequence. `seq_error` pulses in the next cycle and no further access is issued.
- R10: A `start` pulse while `busy` is high is ignored. The order and content of the accesses are unchanged, and only one result pulse follows.
- R11: Each run ends with exactly one of `seq_done`, `seq_timeout` or `seq_error`, high for a single cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | One-cycle request to run the sequence |
| busy | output | 1 | Sequence in progress |
| req_valid | output | 1 | Register access requested |
| req_write | output | 1 | 1 = write, 0 = read |
| req_dev | output | AW | Device address of the access |
| req_reg | output | AW | Register offset of the access |
| req_wdata | output | DW | Write data |
| ack | input | 1 | Access complete |
| ack_rdata | input | DW | Read data, valid with `ack` |
| ack_err | input | 1 | Access failed, valid with `ack` |
| seq_done | output | 1 | Pulse: reset completed |
| seq_timeout | output | 1 | Pulse: reset bit never cleared |
| seq_error | output | 1 | Pulse: an access failed |

## Verification
Random port register contents show whether the read-modify-write keeps every bit outside the state field. A model of the self-clearing bit that stays set for a chosen number of polls covers the main cases. Clearing on the first poll, clearing on the last allowed poll and never clearing separate the done path from the timeout path at the boundary. Error acknowledges are injected at the first access, at the last port write and at the first poll, which shows that every phase stops at once. Random acknowledge latency and a start pulse during a run show that the handshake and the phase order do not depend on target timing or on stray triggers.

// File: rtl/sw_reset_seq.sv
module sw_reset_seq #(
  parameter int NUM_PORTS     = 11,
  parameter int DW            = 16,
  parameter int AW            = 5,
  parameter int PORT_DEV_BASE = 16,
  parameter int GLOBAL_DEV    = 27,
  parameter int CTRL_OFS      = 4,
  parameter int STATE_LSB     = 0,
  parameter int STATE_W       = 2,
  parameter int RESET_BIT     = 15,
  parameter int CYCLES_PER_MS = 125000,
  parameter int DRAIN_MS      = 2,
  parameter int POLL_MS       = 1,
  parameter int MAX_POLLS     = 1000
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  output logic          busy,
  output logic          req_valid,
  output logic          req_write,
  output logic [AW-1:0] req_dev,
  output logic [AW-1:0] req_reg,
  output logic [DW-1:0] req_wdata,
  input  logic          ack,
  input  logic [DW-1:0] ack_rdata,
  input  logic          ack_err,
  output logic          seq_done,
  output logic          seq_timeout,
  output logic          seq_error
);

  localparam int DRAIN_CYC = CYCLES_PER_MS * DRAIN_MS;
  localparam int POLL_CYC  = CYCLES_PER_MS * POLL_MS;
  localparam int MAX_CYC   = (DRAIN_CYC > POLL_CYC) ? DRAIN_CYC : POLL_CYC;
  localparam int TW        = $clog2(MAX_CYC + 1);
  localparam int PW        = $clog2(MAX_POLLS + 1);
  localparam int IW        = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1;
  localparam logic [DW-1:0] STATE_MASK = DW'(((1 << STATE_W) - 1) << STATE_LSB);
  localparam logic [DW-1:0] RST_MASK   = DW'(1) << RESET_BIT;

  typedef enum logic [3:0] {
    S_IDLE, S_PORT_RD, S_PORT_WR, S_DRAIN, S_GLB_RD, S_GLB_WR, S_PROBE, S_GAP
  } state_t;

  state_t          st;
  logic [IW-1:0]   port;
  logic [DW-1:0]   hold;
  logic [TW-1:0]   tick;
  logic [PW-1:0]   polls;

  logic in_port, acc_ok, acc_bad, tick_end;

  assign in_port   = (st == S_PORT_RD) || (st == S_PORT_WR);
  assign req_valid = in_port || (st == S_GLB_RD) || (st == S_GLB_WR) || (st == S_PROBE);
  assign req_write = (st == S_PORT_WR) || (st == S_GLB_WR);
  assign req_dev   = in_port ? AW'(PORT_DEV_BASE + int'(port)) : AW'(GLOBAL_DEV);
  assign req_reg   = AW'(CTRL_OFS);
  assign req_wdata = req_write ? hold : '0;
  assign busy      = (st != S_IDLE);
  assign acc_ok    = req_valid && ack && !ack_err;
  assign acc_bad   = req_valid && ack && ack_err;
  assign tick_end  = (tick == TW'(((st == S_DRAIN) ? DRAIN_CYC : POLL_CYC) - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st          <= S_IDLE;
      port        <= '0;
      hold        <= '0;
      tick        <= '0;
      polls       <= '0;
      seq_done    <= 1'b0;
      seq_timeout <= 1'b0;
      seq_error   <= 1'b0;
    end else begin
      seq_done    <= 1'b0;
      seq_timeout <= 1'b0;
      seq_error   <= 1'b0;
      case (st)
        S_IDLE: if (start) begin
          st   <= S_PORT_RD;
          port <= '0;
        end
        S_PORT_RD: if (acc_ok) begin
          hold <= ack_rdata & ~STATE_MASK;
          st   <= S_PORT_WR;
        end
        S_PORT_WR: if (acc_ok) begin
          if (port == IW'(NUM_PORTS - 1)) begin
            st   <= S_DRAIN;
            tick <= '0;
          end else begin
            port <= port + IW'(1);
            st   <= S_PORT_RD;
          end
        end
        S_DRAIN: if (tick_end) st <= S_GLB_RD;
                 else          tick <= tick + TW'(1);
        S_GLB_RD: if (acc_ok) begin
          hold <= ack_rdata | RST_MASK;
          st   <= S_GLB_WR;
        end
        S_GLB_WR: if (acc_ok) begin
          polls <= '0;
          st    <= S_PROBE;
        end
        S_PROBE: if (acc_ok) begin
          if (!ack_rdata[RESET_BIT]) begin
            seq_done <= 1'b1;
            st       <= S_IDLE;
          end else if (polls == PW'(MAX_POLLS - 1)) begin
            seq_timeout <= 1'b1;
            st          <= S_IDLE;
          end else begin
            polls <= polls + PW'(1);
            tick  <= '0;
            st    <= S_GAP;
          end
        end
        S_GAP: if (tick_end) st <= S_PROBE;
               else          tick <= tick + TW'(1);
        default: st <= S_IDLE;
      endcase
      if (acc_bad) begin
        seq_error <= 1'b1;
        st        <= S_IDLE;
      end
    end
  end

endmodule

// File: rtl/sw_reset_seq_chk.sv
module sw_reset_seq_chk #(
  parameter int DW         = 16,
  parameter int AW         = 5,
  parameter int GLOBAL_DEV = 27,
  parameter int STATE_LSB  = 0,
  parameter int STATE_W    = 2,
  parameter int RESET_BIT  = 15
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start,
  input logic          busy,
  input logic          req_valid,
  input logic          req_write,
  input logic [AW-1:0] req_dev,
  input logic [AW-1:0] req_reg,
  input logic [DW-1:0] req_wdata,
  input logic          ack,
  input logic          ack_err,
  input logic          seq_done,
  input logic          seq_timeout,
  input logic          seq_error
);
  localparam logic [DW-1:0] SMASK = DW'(((1 << STATE_W) - 1) << STATE_LSB);
  logic any_end;
  assign any_end = seq_done || seq_timeout || seq_error;

  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !req_valid);
  assert_start_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy && start |=> busy);
  assert_busy_end_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> any_end);
  assert_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !ack |=> req_valid && $stable(req_dev) && $stable(req_reg)
                          && $stable(req_write) && $stable(req_wdata));
  assert_port_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_write && req_dev != AW'(GLOBAL_DEV) |-> (req_wdata & SMASK) == '0);
  assert_reset_bit_R5: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_write && req_dev == AW'(GLOBAL_DEV) |-> req_wdata[RESET_BIT]);
  assert_err_stop_R9: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && ack && ack_err |=> seq_error && !req_valid);
  assert_one_outcome_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({seq_done, seq_timeout, seq_error}));
  assert_pulse_short_R11: assert property (@(posedge clk) disable iff (!rst_n)
    any_end |=> !any_end);
endmodule

bind sw_reset_seq sw_reset_seq_chk #(
  .DW(DW), .AW(AW), .GLOBAL_DEV(GLOBAL_DEV),
  .STATE_LSB(STATE_LSB), .STATE_W(STATE_W), .RESET_BIT(RESET_BIT)
) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .busy(busy),
  .req_valid(req_valid), .req_write(req_write), .req_dev(req_dev),
  .req_reg(req_reg), .req_wdata(req_wdata), .ack(ack), .ack_err(ack_err),
  .seq_done(seq_done), .seq_timeout(seq_timeout), .seq_error(seq_error)
);

// File: tb/test_sw_reset_seq.sv
`timescale 1ns/1ps
module test_sw_reset_seq;
  localparam int NP   = 11;
  localparam int CPM  = 3;
  localparam int DMS  = 2;
  localparam int PMS  = 1;
  localparam int MAXP = 20;
  localparam int DCYC = CPM * DMS;
  localparam int PCYC = CPM * PMS;
  localparam int NPRE = 2 * NP + 2;

  logic clk = 0, rst_n = 0, start = 0;
  logic busy, req_valid, req_write, ack = 0, ack_err = 0;
  logic [4:0] req_dev, req_reg;
  logic [15:0] req_wdata, ack_rdata = 0;
  logic seq_done, seq_timeout, seq_error;

  always #4 clk = ~clk;

  sw_reset_seq #(.NUM_PORTS(NP), .CYCLES_PER_MS(CPM), .DRAIN_MS(DMS),
                 .POLL_MS(PMS), .MAX_POLLS(MAXP)) i_sw_reset_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .busy(busy),
    .req_valid(req_valid), .req_write(req_write), .req_dev(req_dev),
    .req_reg(req_reg), .req_wdata(req_wdata), .ack(ack),
    .ack_rdata(ack_rdata), .ack_err(ack_err), .seq_done(seq_done),
    .seq_timeout(seq_timeout), .seq_error(seq_error));

  int checks = 0, errors = 0;
  bit finished = 0;
  logic [15:0] port_mem [0:NP-1];
  logic [15:0] glb_mem;
  int set_left, set_reads, err_at, lat_max, req_idx, wcnt;
  bit armed;
  int gaps [0:255];
  int ngap, idle;

  task automatic chk(input bit ok, input string rq, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", rq, what, act, exp);
    end
  endtask

  function automatic int exp_dev(input int i);
    return (i < 2 * NP) ? 16 + i / 2 : 27;
  endfunction

  function automatic bit exp_wr(input int i);
    return (i < 2 * NP) ? bit'(i % 2) : (i == 2 * NP + 1);
  endfunction

  function automatic logic [15:0] exp_wdata(input int i);
    if (i < 2 * NP) return port_mem[i / 2] & 16'hFFFC;
    return glb_mem | 16'h8000;
  endfunction

  always @(negedge clk) begin
    if (!rst_n) begin
      ack = 0; ack_err = 0; armed = 0; idle = 0;
    end else begin
      ack = 0; ack_err = 0;
      if (busy && !req_valid) idle++;
      else if (req_valid && idle > 0) begin
        if (ngap < 256) gaps[ngap] = idle;
        ngap++; idle = 0;
      end
      if (!busy) idle = 0;
      if (req_valid) begin
        if (!armed) begin
          armed = 1;
          wcnt = $urandom_range(0, lat_max);
          // R3 port accesses, R5 global accesses, R6 polls
          chk(req_dev == 5'(exp_dev(req_idx)) && req_reg == 5'd4 &&
              req_write == exp_wr(req_idx) &&
              (!req_write || req_wdata == exp_wdata(req_idx)),
              (req_idx < 2 * NP) ? "R3" : ((req_idx < NPRE) ? "R5" : "R6"),
              "access fields", {req_write, req_dev, req_wdata},
              {exp_wr(req_idx), 5'(exp_dev(req_idx)), exp_wr(req_idx) ? exp_wdata(req_idx) : req_wdata});
        end
        if (wcnt == 0) begin
          ack = 1; armed = 0;
          ack_rdata = 16'($urandom);
          if (req_idx == err_at) ack_err = 1;
          else if (req_idx < 2 * NP) begin
            if (req_idx % 2 == 0) ack_rdata = port_mem[req_idx / 2];
            else port_mem[req_idx / 2] = req_wdata;
          end else if (req_idx == 2 * NP) ack_rdata = glb_mem;
          else if (req_idx == 2 * NP + 1) begin
            glb_mem = req_wdata; set_left = set_reads;
          end else begin
            ack_rdata = glb_mem;
            ack_rdata[15] = (set_left > 0);
            if (set_left > 0) set_left--;
          end
          req_idx++;
        end else wcnt--;
      end
    end
  end

  task automatic run_case(input int k, input int errat, input int lmax, input bit restart);
    int polls, nreq;
    bit got;
    string outc;
    for (int p = 0; p < NP; p++) port_mem[p] = 16'($urandom);
    glb_mem = 16'($urandom);
    set_reads = k; err_at = errat; lat_max = lmax;
    req_idx = 0; ngap = 0;
    polls = (k < MAXP) ? k + 1 : MAXP;
    if (errat >= 0 && errat < NPRE + polls) begin
      nreq = errat + 1; outc = "err";
    end else begin
      nreq = NPRE + polls; outc = (k < MAXP) ? "done" : "tout";
    end
    @(negedge clk) start = 1;
    @(negedge clk) start = 0;
    chk(busy == 1, "R1", "busy after start", busy, 1);
    if (restart) begin
      repeat (7) @(negedge clk);
      start = 1;
      @(negedge clk) start = 0;
      repeat (30) @(negedge clk);
      start = 1;
      @(negedge clk) start = 0;
    end
    got = 0;
    for (int c = 0; c < 20000 && !got; c++) begin
      @(negedge clk);
      if (seq_done || seq_timeout || seq_error) got = 1;
    end
    chk(got, "R11", "result pulse seen", got, 1);
    chk(busy == 0, "R1", "busy low with pulse", busy, 0);
    chk({seq_done, seq_timeout, seq_error} ==
        ((outc == "done") ? 3'b100 : (outc == "tout") ? 3'b010 : 3'b001),
        (outc == "done") ? "R6" : (outc == "tout") ? "R8" : "R9", "outcome",
        {seq_done, seq_timeout, seq_error},
        (outc == "done") ? 3'b100 : (outc == "tout") ? 3'b010 : 3'b001);
    @(negedge clk);
    chk({seq_done, seq_timeout, seq_error} == 0, "R11", "pulse one cycle",
        {seq_done, seq_timeout, seq_error}, 0);
    repeat (12) @(negedge clk);
    chk(req_idx == nreq && !req_valid, restart ? "R10" : (outc == "err") ? "R9" : "R8",
        "access count", req_idx, nreq);
    if (outc != "err") begin
      chk(ngap == polls, "R7", "gap count", ngap, polls);
      chk(gaps[0] == DCYC, "R4", "drain gap", gaps[0], DCYC);
      for (int g = 1; g < ngap && g < 256; g++)
        chk(gaps[g] == PCYC, "R7", "poll gap", gaps[g], PCYC);
    end
  endtask

  initial begin
    void'($urandom(32'd1234));
    set_reads = 0; err_at = -1; lat_max = 0; req_idx = 0; ngap = 0;
    repeat (3) @(negedge clk);
    chk({busy, req_valid, seq_done, seq_timeout, seq_error} == 0, "R1", "reset state",
        {busy, req_valid, seq_done, seq_timeout, seq_error}, 0);
    rst_n = 1;
    @(negedge clk);
    run_case(0, -1, 0, 0);
    run_case(MAXP - 1, -1, 2, 0);
    run_case(MAXP, -1, 1, 0);
    run_case(0, 0, 1, 0);
    run_case(3, 2 * NP - 1, 2, 0);
    run_case(5, NPRE, 0, 0);
    run_case(4, -1, 3, 1);
    for (int r = 0; r < 8; r++) begin
      int kk, ee;
      kk = $urandom_range(0, MAXP);
      ee = ($urandom_range(0, 3) == 0) ? $urandom_range(0, NPRE + 4) : -1;
      run_case(kk, ee, $urandom_range(0, 3), 0);
    end
    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(8 * 150000);
    if (!finished) begin
      chk(0, "R11", "watchdog expired", 0, 1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule